// File: doc/BRIEF.md
# Clocked Serial Character Receiver with Hex Display

This block takes in single characters sent over a two-wire synchronous link, where the sender drives both a data wire and a link clock wire, and there is no framing or select wire. The receiver brings both wires into its own system clock domain and takes one data bit on each rising edge of the link clock that it sees. It counts bits to find the end of a character. When the sender stops partway through a character, a timeout throws away the partial bits.

Every complete 7-bit character is copied into a display register. A single-cycle strobe marks its arrival. The stored code appears as two hexadecimal digits on two seven-segment outputs that are driven in parallel. The upper three code bits form the high digit and the lower four form the low digit. The normal payload is the ASCII code of one hex digit character, so for example the character `A` (0x41) shows as "41".

Top module: `hexlink_rx`

## Requirements
- R1: While reset is held and after it is released, both segment outputs show the glyph for 0 (0x3F) and the strobe is low, until the first complete character arrives.
- R2: Each character is 7 bits, taken most significant bit first. Each bit is the synchronised data value at a synchronised rising edge of the link clock. The display register takes the character on the seventh edge.
- R3: The strobe `rx_valid` goes high for exactly one system clock for each completed character, in the same cycle that the new value first appears on the segment outputs.
- R4: `seg_lo` shows code bits 3..0 as a hex glyph, active high, with bit 0 = segment a up to bit 6 = segment g. The glyphs for 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R5: `seg_hi` shows code bits 6..4 with a leading zero, so it only ever shows one of the glyphs for 0 to 7.
- R6: If a partial character is held and no link clock rising edge arrives for more than 64 system clocks, the partial bits are dropped, and the next character is received whole.
- R7: Between characters the display holds its value, and changes on the data wire with no link clock edge do not change the outputs or raise the strobe.
- R8: Gaps of up to 64 system clocks between successive link clock rising edges do not drop any bits of a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_clk | input | 1 | Link clock from the sender, asynchronous |
| link_dat | input | 1 | Link data from the sender, asynchronous |
| seg_hi | output | 7 | High hex digit segments, gfedcba, active high |
| seg_lo | output | 7 | Low hex digit segments, gfedcba, active high |
| rx_valid | output | 1 | One-cycle pulse per received character |

## Verification
A wrong bit count or a lost edge shows up at the ports within one character. The strobe arrives early or late against the bench's queue of expected characters, and every character after that decodes shifted. An idle counter that is too short drops bits of a slowly clocked character. One that is too long lets stale bits merge into the next character, and the first character after the stall then shows the wrong glyphs. Display register faults show up on the segment outputs several cycles after the strobe, or as glyph changes while the link is quiet.

// File: rtl/hexlink_pkg.sv
// Package: shared widths and the digit-pair type for the hex link receiver.
// Assumes two display digits of four bits each.
package hexlink_pkg;
    localparam int DIG_W  = 4;
    localparam int SEG_W  = 7;
    localparam int N_DIGS = 2;

    // Pair of display nibbles, high digit first.
    typedef struct packed {
        logic [DIG_W-1:0] hi;
        logic [DIG_W-1:0] lo;
    } digit_pair_t;
endpackage

// File: rtl/hexlink_sync.sv
// Module: hexlink_sync
// Brings the link clock and data into the system domain through a
// flop chain of STAGES depth each, then flags a rising edge of the link clock.
// Assumes the sender holds data steady for a few system clocks around each
// link clock rise, so the data seen at the flagged edge is the intended bit.
module hexlink_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_clk,
    input  logic link_dat,
    output logic edge_rise,
    output logic dat_sync
);
    logic [STAGES-1:0] clk_pipe;
    logic [STAGES-1:0] dat_pipe;
    logic              clk_last;

    // Shift both link wires through their synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_pipe <= '0;
            dat_pipe <= '0;
        end else begin
            clk_pipe <= {clk_pipe[STAGES-2:0], link_clk};
            dat_pipe <= {dat_pipe[STAGES-2:0], link_dat};
        end
    end

    // Hold the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_last <= 1'b0;
        else        clk_last <= clk_pipe[STAGES-1];
    end

    // A rise is the synchronised level high after a low.
    always_comb begin
        edge_rise = clk_pipe[STAGES-1] & ~clk_last;
        dat_sync  = dat_pipe[STAGES-1];
    end
endmodule

// File: rtl/hexlink_shifter.sv
// Module: hexlink_shifter
// Collects DATA_BITS bits MSB first, one per flagged link clock rise. On the
// last bit it copies the character into the display register and pulses done.
// A partial character is dropped after more than IDLE_LIMIT clocks with no rise.
// Assumes DATA_BITS >= 3.
module hexlink_shifter #(
    parameter int DATA_BITS  = 7,
    parameter int IDLE_LIMIT = 64,
    localparam int CNT_W     = $clog2(DATA_BITS + 1),
    localparam int IDLE_W    = $clog2(IDLE_LIMIT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_rise,
    input  logic                 bit_val,
    output logic [DATA_BITS-1:0] char_q,
    output logic                 char_done,
    output logic [CNT_W-1:0]     bit_cnt,
    output logic [IDLE_W-1:0]    idle_cnt
);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_BITS - 1);
    localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_LIMIT);

    logic [DATA_BITS-2:0] part_q;
    logic                 last_bit;
    logic                 stale;

    // Decode the last bit of a character and the idle timeout condition.
    always_comb begin
        last_bit = bit_rise && (bit_cnt == LAST_BIT);
        stale    = !bit_rise && (bit_cnt != '0) && (idle_cnt == IDLE_MAX);
    end

    // Shift in bits and count them, and clear on timeout or a full character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q  <= '0;
            bit_cnt <= '0;
        end else if (last_bit || stale) begin
            part_q  <= '0;
            bit_cnt <= '0;
        end else if (bit_rise) begin
            part_q  <= {part_q[DATA_BITS-3:0], bit_val};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Count system clocks since the last rise while a partial character is held.
    always_ff @(posedge clk) begin
        if (!rst_n)                        idle_cnt <= '0;
        else if (bit_rise || stale)        idle_cnt <= '0;
        else if (bit_cnt != '0)            idle_cnt <= idle_cnt + 1'b1;
        else                               idle_cnt <= '0;
    end

    // Copy the complete character to the display register and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q    <= '0;
            char_done <= 1'b0;
        end else begin
            char_done <= last_bit;
            if (last_bit) char_q <= {part_q, bit_val};
        end
    end
endmodule

// File: rtl/hexlink_seg.sv
// Module: hexlink_seg
// Turns one hex nibble into an active-high seven-segment glyph, with
// bit 0 = segment a up to bit 6 = segment g. Purely combinational.
module hexlink_seg
    import hexlink_pkg::*;
(
    input  logic [DIG_W-1:0] nib,
    output logic [SEG_W-1:0] seg
);
    // Look up the glyph for the nibble.
    always_comb begin
        case (nib)
            4'h0: seg = 7'h3F;
            4'h1: seg = 7'h06;
            4'h2: seg = 7'h5B;
            4'h3: seg = 7'h4F;
            4'h4: seg = 7'h66;
            4'h5: seg = 7'h6D;
            4'h6: seg = 7'h7D;
            4'h7: seg = 7'h07;
            4'h8: seg = 7'h7F;
            4'h9: seg = 7'h6F;
            4'hA: seg = 7'h77;
            4'hB: seg = 7'h7C;
            4'hC: seg = 7'h39;
            4'hD: seg = 7'h5E;
            4'hE: seg = 7'h79;
            default: seg = 7'h71;
        endcase
    end
endmodule

// File: rtl/hexlink_rx.sv
// Module: hexlink_rx (top)
// Receives a character over a data plus clock link and shows it as two hex digits.
// Assumes DATA_BITS fits in N_DIGS nibbles. Upper nibble bits above the code are zero.
module hexlink_rx
    import hexlink_pkg::*;
#(
    parameter int DATA_BITS   = 7,
    parameter int IDLE_LIMIT  = 64,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DATA_BITS + 1),
    localparam int IDLE_W     = $clog2(IDLE_LIMIT + 1),
    localparam int PAD_W      = N_DIGS * DIG_W - DATA_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_clk,
    input  logic             link_dat,
    output logic [SEG_W-1:0] seg_hi,
    output logic [SEG_W-1:0] seg_lo,
    output logic             rx_valid
);
    logic                 lclk_rise;
    logic                 ldat;
    logic [DATA_BITS-1:0] code_q;
    logic [CNT_W-1:0]     bit_cnt;
    logic [IDLE_W-1:0]    idle_cnt;
    digit_pair_t          digits;
    logic [SEG_W-1:0]     seg_arr [N_DIGS];

    hexlink_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_clk  (link_clk),
        .link_dat  (link_dat),
        .edge_rise (lclk_rise),
        .dat_sync  (ldat)
    );

    hexlink_shifter #(.DATA_BITS(DATA_BITS), .IDLE_LIMIT(IDLE_LIMIT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_rise  (lclk_rise),
        .bit_val   (ldat),
        .char_q    (code_q),
        .char_done (rx_valid),
        .bit_cnt   (bit_cnt),
        .idle_cnt  (idle_cnt)
    );

    // Pad the code with leading zeros and split it into display nibbles.
    always_comb digits = digit_pair_t'({{PAD_W{1'b0}}, code_q});

    // One glyph encoder per digit, index 0 = low, index 1 = high.
    for (genvar g = 0; g < N_DIGS; g++) begin : g_dig
        hexlink_seg u_seg (
            .nib (digits[g*DIG_W +: DIG_W]),
            .seg (seg_arr[g])
        );
    end

    // Route the encoded glyphs to the output ports.
    always_comb begin
        seg_lo = seg_arr[0];
        seg_hi = seg_arr[1];
    end
endmodule

// File: rtl/hexlink_rx_chk.sv
// Module: hexlink_rx_chk
// Assertion checker bound into hexlink_rx. It watches the ports and the
// internal counters.
module hexlink_rx_chk #(
    parameter int DATA_BITS  = 7,
    parameter int IDLE_LIMIT = 64,
    localparam int CNT_W     = $clog2(DATA_BITS + 1),
    localparam int IDLE_W    = $clog2(IDLE_LIMIT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [6:0]        seg_hi,
    input logic [6:0]        seg_lo,
    input logic              lclk_rise,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [IDLE_W-1:0] idle_cnt
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R3

    AST_STROBE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(lclk_rise)); // R2

    AST_DISPLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(seg_hi) && $stable(seg_lo))); // R7

    AST_HIGH_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_hi == 7'h3F || seg_hi == 7'h06 || seg_hi == 7'h5B || seg_hi == 7'h4F ||
         seg_hi == 7'h66 || seg_hi == 7'h6D || seg_hi == 7'h7D || seg_hi == 7'h07)); // R5

    AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CNT_W'(DATA_BITS)); // R2

    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= IDLE_W'(IDLE_LIMIT)); // R6

    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt == IDLE_W'(IDLE_LIMIT) && !lclk_rise && bit_cnt != '0) |=> (bit_cnt == '0)); // R6
endmodule

bind hexlink_rx hexlink_rx_chk #(.DATA_BITS(DATA_BITS), .IDLE_LIMIT(IDLE_LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .seg_hi    (seg_hi),
    .seg_lo    (seg_lo),
    .lclk_rise (lclk_rise),
    .bit_cnt   (bit_cnt),
    .idle_cnt  (idle_cnt)
);

// File: tb/hexlink_rx_tb.sv
// Scoreboard bench for hexlink_rx: the driver queues expected glyph pairs and
// the monitor pops and compares them on each strobe.
module hexlink_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_clk = 1'b0;
    logic       link_dat = 1'b0;
    logic [6:0] seg_hi;
    logic [6:0] seg_lo;
    logic       rx_valid;

    int n_checks = 0;
    int n_errors = 0;
    logic [13:0] exp_q [$];
    logic [13:0] last_exp = {7'h3F, 7'h3F};
    logic        prev_valid = 1'b0;

    always #4 clk = ~clk;

    hexlink_rx u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_clk (link_clk),
        .link_dat (link_dat),
        .seg_hi   (seg_hi),
        .seg_lo   (seg_lo),
        .rx_valid (rx_valid)
    );

    // Glyph values stated in R4.
    function automatic logic [6:0] glyph(input logic [3:0] v);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[v];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nb bits of code MSB first; half is the half period in system clocks.
    task automatic send_bits(input logic [6:0] code, input int nb, input int half);
        for (int i = 6; i > 6 - nb; i--) begin
            link_dat = code[i];
            wait_clks(half);
            link_clk = 1'b1;
            wait_clks(half);
            link_clk = 1'b0;
        end
    endtask

    // Queue the expected display and send a full character.
    task automatic send_char(input logic [6:0] code, input int half);
        logic [13:0] e;
        e = {glyph({1'b0, code[6:4]}), glyph(code[3:0])};
        exp_q.push_back(e);
        last_exp = e;
        send_bits(code, 7, half);
        wait_clks(12);
        check("R4/R5 display after character", {18'd0, seg_hi, seg_lo}, {18'd0, e});
    endtask

    // Monitor: compare each strobe against the scoreboard; strobe width check.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && prev_valid) begin
                n_checks++; n_errors++;
                $display("FAIL R3: strobe high two cycles actual=1 expected=0");
            end
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_errors++;
                    $display("FAIL R7: unexpected strobe actual=%0h expected=none", {seg_hi, seg_lo});
                end else begin
                    check("R2/R3 strobe value", {18'd0, seg_hi, seg_lo}, {18'd0, exp_q.pop_front()});
                end
            end
        end
        prev_valid = rx_valid;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        wait_clks(3);
        check("R1 reset seg_hi", {25'd0, seg_hi}, 32'h3F);
        check("R1 reset seg_lo", {25'd0, seg_lo}, 32'h3F);
        check("R1 reset strobe", {31'd0, rx_valid}, 32'd0);
        rst_n = 1'b1;
        wait_clks(20);
        check("R1 idle after reset", {18'd0, seg_hi, seg_lo}, {18'd0, 7'h3F, 7'h3F});

        // R2/R4: all sixteen hex digit characters.
        for (int d = 0; d < 16; d++) begin
            send_char((d < 10) ? 7'(8'h30 + d) : 7'(8'h37 + d), 4);
        end
        send_char(7'h7F, 4);   // R5 top high digit
        send_char(7'h0A, 3);   // R5 zero high digit

        // R7: data toggles without link clock edges.
        for (int i = 0; i < 40; i++) begin
            link_dat = ~link_dat;
            wait_clks(3);
        end
        check("R7 display holds", {18'd0, seg_hi, seg_lo}, {18'd0, last_exp});
        check("R7 no pending char", exp_q.size(), 0);

        // R6: partial character then a long stall, then a fresh character.
        send_bits(7'h7F, 3, 4);
        wait_clks(200);
        check("R6 partial dropped, display held", {18'd0, seg_hi, seg_lo}, {18'd0, last_exp});
        send_char(7'h35, 4);

        // R8: slow link with 60-clock gaps between rises.
        send_char(7'h43, 30);

        wait_clks(20);
        check("R3 every character strobed", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule